// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

The block is a per-core countdown timer that raises an interrupt request toward the local interrupt controller. Software programs a divide setting, a timer entry (vector, mask, periodic/one-shot) and an initial count through a small register port. Writing the initial count loads the counter and restarts the prescaler. The counter then steps down once per prescaled tick.

When the count reaches zero, the block emits a one-cycle request strobe carrying the programmed vector, unless the entry is masked. In one-shot mode the count then parks at zero. In periodic mode the next tick reloads the initial count, so one period spans initial count plus one ticks. An initial count of zero halts the timer. The mode bit is sampled on every tick, so rewriting the entry changes how the timer behaves from the next tick on.

Top module: `local_irq_timer`

## Requirements
- R1: The divide register keeps only bits 0, 1 and 3 of a write. A read at select 3 returns the written value AND 0xB.
- R2: The divide code is {bit3, bit1, bit0} of the divide register. The tick period is 2^((code+1) mod 8) clock cycles, so code 7 ticks every cycle and code 0 ticks every 2 cycles.
- R3: A write to the initial count (select 1) loads that value and restarts the prescaler. After e cycles with D cycles per tick, one-shot mode reads current count (select 2) as max(N - floor(e/D), 0). A later rewrite restarts timing from that write.
- R4: In one-shot mode the request fires once, on the tick that brings the count to 0, which is N*D cycles after the load. The count then stays at 0.
- R5: In periodic mode the current count reads N - (j mod (N+1)) after j ticks. A request fires every (N+1)*D cycles, starting N*D cycles after the load.
- R6: When the entry mask bit (bit 8) is set, expiry raises no request. The count still runs.
- R7: irq_o is a single-cycle strobe, and irq_vec_o carries the vector field (entry bits 7:0) at that expiry.
- R8: An initial count of 0 stops the timer. The current count reads 0 and no request is raised.
- R9: The periodic bit (entry bit 9) is evaluated on every tick. Setting it while a one-shot count is parked at 0 reloads N on the next tick, and periodic requests resume.
- R10: After reset the entry (select 0) reads 0x100 (masked, vector 0, one-shot). Initial count, current count and divide register read 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 entry, 1 initial count, 2 current count (read-only), 3 divide |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request strobe |
| irq_vec_o | output | 8 | Vector accompanying the strobe |

## Verification
Several divide codes (1, 2, 16 and 32 cycles per tick) are run against one-shot counts. Comparing expiry cycles and mid-run count reads across them shows whether the non-contiguous code bits and the +1 shift are decoded correctly. A periodic run with a small count checks the N+1 reload period, including the zero state, and separates it from an off-by-one reload. Masked, zero-count, mid-run reload and live mode-switch patterns each predict a distinct request schedule, and the scoreboard compares every strobe's cycle and vector against that schedule.

// File: rtl/local_irq_timer_pkg.sv
package local_irq_timer_pkg;
  localparam int VEC_W = 8;
  localparam int PRE_W = 7;            // largest shift is 7
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_CURR  = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  function automatic logic [2:0] div_shift(logic [3:0] div);
    logic [2:0] code;
    code = {div[3], div[1:0]};
    return code + 3'd1;               // wraps: code 7 -> shift 0
  endfunction
endpackage

// File: rtl/local_irq_timer_regs.sv
module local_irq_timer_regs
  import local_irq_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cur_cnt_i,
  output entry_t            entry_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [3:0]        div_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  entry_t   entry_q;
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;

  assign sel    = reg_sel_e'(addr_i);
  assign load_o = we_i && (sel == SEL_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
      init_q  <= '0;
      div_q   <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_ENTRY: entry_q <= entry_t'(wdata_i[ENTRY_W-1:0]);
        SEL_INIT:  init_q  <= wdata_i[CNT_W-1:0];
        SEL_DIV:   div_q   <= wdata_i[3:0] & DIV_KEEP;
        default:   ;                  // current count is read-only
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENTRY: rdata_o = DATA_W'(entry_q);
      SEL_INIT:  rdata_o = DATA_W'(init_q);
      SEL_CURR:  rdata_o = DATA_W'(cur_cnt_i);
      default:   rdata_o = DATA_W'(div_q);
    endcase
  end

  assign entry_o = entry_q;
  assign init_o  = init_q;
  assign div_o   = div_q;
endmodule

// File: rtl/local_irq_timer_prescale.sv
module local_irq_timer_prescale
  import local_irq_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [2:0] shift_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  // tick when the low 'shift' bits are all ones
  for (genvar i = 0; i < PRE_W; i++) begin : g_sel
    assign sel[i] = (3'(i) < shift_i) ? pre_q[i] : 1'b1;
  end

  assign tick_o = &sel;
endmodule

// File: rtl/local_irq_timer_count.sv
module local_irq_timer_count
  import local_irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  entry_t           entry_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             run;

  assign run = tick_i && (init_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      irq_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == '0) begin
        if (entry_i.periodic) cnt_q <= init_i;
        irq_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
        irq_q <= (cnt_q == ONE) && !entry_i.mask;
        if (cnt_q == ONE) vec_q <= entry_i.vector;
      end
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer
  import local_irq_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  entry_t           entry_q;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       div_q;
  logic             load;
  logic             tick;

  local_irq_timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .cur_cnt_i(cnt_q),
    .entry_o  (entry_q),
    .init_o   (init_q),
    .div_o    (div_q),
    .load_o   (load),
    .rdata_o  (reg_rdata_o)
  );

  local_irq_timer_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .shift_i(div_shift(div_q)),
    .tick_o (tick)
  );

  local_irq_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .init_i    (init_q),
    .tick_i    (tick),
    .entry_i   (entry_q),
    .cnt_o     (cnt_q),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o)
  );
endmodule

// File: rtl/local_irq_timer_chk.sv
module local_irq_timer_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              irq_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  init_i,
  input logic              mask_i,
  input logic              periodic_i
);
  assert_div_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> ((rdata_i & ~DATA_W'(4'hB)) == '0));

  assert_irq_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cnt_i == '0));

  assert_oneshot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic_i && cnt_i == '0 && !(we_i && addr_i == 2'd1)) |=> (cnt_i == '0));

  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= init_i);

  assert_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> !$past(mask_i));

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  assert_zero_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i == '0) |-> !irq_i);
endmodule

bind local_irq_timer local_irq_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .rdata_i   (reg_rdata_o),
  .irq_i     (irq_o),
  .cnt_i     (cnt_q),
  .init_i    (init_q),
  .mask_i    (entry_q.mask),
  .periodic_i(entry_q.periodic)
);

// File: tb/local_irq_timer_bench.sv
`timescale 1ns/1ps
module local_irq_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  irq_vec;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_t[$];
  logic [7:0] exp_v[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  local_irq_timer u_local_irq_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  task automatic chk(int got, int exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // monitor: compare every strobe against the expected schedule (R4 R5 R7)
  always @(negedge clk) begin
    if (rst_n && irq) begin
      n_chk++;
      if (exp_t.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected strobe: got cycle %0d vec 0x%0h expected none", cyc, irq_vec);
      end else begin
        if (cyc != exp_t[0] || irq_vec != exp_v[0]) begin
          n_fail++;
          $display("FAIL R7 strobe: got cycle %0d vec 0x%0h expected cycle %0d vec 0x%0h",
                   cyc, irq_vec, exp_t[0], exp_v[0]);
        end
        void'(exp_t.pop_front());
        void'(exp_v.pop_front());
      end
    end
  end

  // write lands at the edge where cyc becomes t; returns that cycle
  task automatic wr_at(int t, logic [1:0] a, logic [31:0] d, output int t0);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    t0 = cyc;
    we = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, output int t0);
    wr_at(cyc + 1, a, d, t0);
  endtask

  task automatic peek_at(int t, logic [1:0] a, output int v);
    @(negedge clk);
    while (cyc < t) @(negedge clk);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic expect_irq(int t, logic [7:0] v);
    exp_t.push_back(t);
    exp_v.push_back(v);
  endtask

  task automatic run_tests();
    int t0, t1, tw, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    peek_at(cyc, 2'd0, v); chk(v, 32'h100, "R10 entry reset");
    peek_at(cyc, 2'd1, v); chk(v, 0, "R10 init reset");
    peek_at(cyc, 2'd2, v); chk(v, 0, "R10 count reset");
    peek_at(cyc, 2'd3, v); chk(v, 0, "R10 divide reset");
    chk(int'(irq), 0, "R10 irq low");

    // R1 divide bit filtering
    wr(2'd3, 32'hFF, t0); peek_at(cyc, 2'd3, v); chk(v, 32'hB, "R1 divide 0xFF");
    wr(2'd3, 32'h4, t0);  peek_at(cyc, 2'd3, v); chk(v, 32'h0, "R1 divide 0x4");

    // R3/R4 one-shot, divide by 1 (code 7)
    wr(2'd3, 32'hB, t0);
    wr(2'd0, 32'h031, t0);
    wr(2'd1, 5, t0); expect_irq(t0 + 5, 8'h31);
    peek_at(t0 + 2, 2'd2, v); chk(v, 3, "R3 count div1");
    peek_at(t0 + 8, 2'd2, v); chk(v, 0, "R4 parked at zero");
    peek_at(t0 + 20, 2'd2, v); chk(v, 0, "R4 stays zero");

    // R2 divide by 2 (code 0)
    wr(2'd3, 32'h0, t0);
    wr(2'd0, 32'h042, t0);
    wr(2'd1, 3, t0); expect_irq(t0 + 6, 8'h42);
    peek_at(t0 + 3, 2'd2, v); chk(v, 2, "R2 count div2");
    peek_at(t0 + 12, 2'd2, v); chk(v, 0, "R2 div2 expired");

    // R2 divide by 16 (code 3)
    wr(2'd3, 32'h3, t0);
    wr(2'd1, 2, t0); expect_irq(t0 + 32, 8'h42);
    peek_at(t0 + 17, 2'd2, v); chk(v, 1, "R2 count div16");

    // R2 divide by 32 (code 4, bit 3 set)
    wr_at(t0 + 40, 2'd3, 32'h8, t1);
    wr(2'd1, 1, t0); expect_irq(t0 + 32, 8'h42);
    peek_at(t0 + 31, 2'd2, v); chk(v, 1, "R2 div32 before tick");
    peek_at(t0 + 32, 2'd2, v); chk(v, 0, "R2 div32 at tick");

    // R5 periodic, divide by 1
    wr(2'd3, 32'hB, t0);
    wr(2'd0, 32'h255, t0);
    wr(2'd1, 3, t0);
    expect_irq(t0 + 3, 8'h55); expect_irq(t0 + 7, 8'h55); expect_irq(t0 + 11, 8'h55);
    peek_at(t0 + 5, 2'd2, v); chk(v, 2, "R5 periodic count");
    peek_at(t0 + 8, 2'd2, v); chk(v, 3, "R5 reload includes zero");
    // R8 stop with zero
    wr_at(t0 + 13, 2'd1, 0, t1);
    peek_at(t1 + 1, 2'd2, v); chk(v, 0, "R8 zero count stops");
    peek_at(t1 + 40, 2'd2, v); chk(v, 0, "R8 stays stopped");

    // R6 masked one-shot
    wr(2'd0, 32'h160, t0);
    wr(2'd1, 4, t0);
    peek_at(t0 + 2, 2'd2, v); chk(v, 2, "R6 masked still counts");
    peek_at(t0 + 10, 2'd2, v); chk(v, 0, "R6 masked expired silently");

    // R3 restart by rewrite
    wr(2'd0, 32'h011, t0);
    wr(2'd1, 10, t0);
    wr_at(t0 + 4, 2'd1, 6, t1); expect_irq(t1 + 6, 8'h11);
    peek_at(t1 + 1, 2'd2, v); chk(v, 5, "R3 restart count");
    peek_at(t1 + 10, 2'd2, v); chk(v, 0, "R3 restart expired");

    // R9 live switch from parked one-shot to periodic
    wr(2'd0, 32'h077, t0);
    wr(2'd1, 2, t0); expect_irq(t0 + 2, 8'h77);
    wr_at(t0 + 6, 2'd0, 32'h277, tw);
    expect_irq(tw + 3, 8'h77); expect_irq(tw + 6, 8'h77);
    peek_at(tw + 1, 2'd2, v); chk(v, 2, "R9 reload after switch");
    wr_at(tw + 8, 2'd1, 0, t1);
    repeat (20) @(negedge clk);
    chk(exp_t.size(), 0, "R7 all expected strobes seen");
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule